// File: doc/BRIEF.md
# Two-Sample Quadrature Generator

This block turns a stream of signed fixed-point samples of a single-phase voltage into a pair of orthogonal components. The in-phase word is the current sample. The quadrature word is built from the current sample and the two samples before it. It uses a closed-form finite-difference expression whose two scale factors depend on the number of samples per fundamental period, N. Only a two-entry history is stored, and the block contains no trigonometric unit and no divider.

Two coefficient sources are selectable. In exact mode the caller supplies the words 1/sin(4π/N) and tan(2π/N). In small-angle mode the block forms N/(4π) from the samples-per-period word by multiplying with a constant. It takes 2π/N directly as a phase-step word, which is the same quantity a frequency estimator already produces as ω'·Ts. N may be a fixed constant or follow the estimated frequency. Results emerge two clocks after each sample strobe, fully pipelined.

Top module: `quad_two_sample`

## Requirements
- R1: While `rstN` is low, `outValid`, `alphaOut` and `betaOut` are all zero.
- R2: After reset, the first two strobed samples produce no `outValid` pulse. Every later strobed sample produces exactly one.
- R3: A sample strobed at clock edge E produces its result, with `outValid` high for one cycle, from edge E+2. Outputs change at no other time.
- R4: In exact mode (`approxMode`=0), `betaOut` = sat((x[k-2] − x[k])·`invSinCoef` + x[k]·`tanCoef`) >>> 12. The coefficients are signed with 12 fractional bits, and >>> is an arithmetic right shift (floor).
- R5: In small-angle mode (`approxMode`=1), the first coefficient is floor(`periodWord`·5215 / 256). Here `periodWord` is unsigned with 4 fractional bits and 5215 = round(2^16/(4π)). The second coefficient is `phaseStep` (signed, 12 fractional bits). The rest of the expression is the same as in R4.
- R6: The full-precision sum is saturated once, to the range −32768..32767.
- R7: `alphaOut` presents x[k], the sample whose quadrature value appears on `betaOut` in the same cycle.
- R8: Changes on `sampleIn` while `sampleStb` is low do not enter the history and have no effect on any result.
- R9: Strobes on consecutive clock cycles are each processed, one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | 16 | Signed input sample |
| sampleStb | input | 1 | Sample strobe, one cycle per sample |
| approxMode | input | 1 | 1 selects small-angle coefficients |
| periodWord | input | 12 | Samples per period, unsigned, 4 fractional bits |
| phaseStep | input | 18 | 2π/N, signed, 12 fractional bits |
| invSinCoef | input | 18 | 1/sin(4π/N), signed, 12 fractional bits |
| tanCoef | input | 18 | tan(2π/N), signed, 12 fractional bits |
| alphaOut | output | 16 | In-phase output |
| betaOut | output | 16 | Quadrature output |
| outValid | output | 1 | Result strobe |

## Verification
The bench uses the default widths: 16-bit samples, 18-bit coefficients with 12 fractional bits, and a 12-bit period word with 4 fractional bits. At these widths, full-scale samples combined with a coefficient near 7.3 overflow the sum in both directions, so the saturation path is reachable. Realistic settings of N = 64 in exact mode and N = 100 in small-angle mode exercise the scaled-constant path. Bursts of back-to-back strobes and a reset in the middle of the run cover pipelining and history priming.

// File: rtl/quad2s_pkg.sv
package quad2s_pkg;
  // Strobes from control to datapath, one per pipeline stage
  typedef struct packed {
    logic shift;   // capture a new sample into the history
    logic mul;     // form the two products
    logic sum;     // add, scale, saturate and present
    logic primed;  // the sample in the sum stage had two predecessors
  } ctlStrobes_t;

  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 18;
  localparam int COEF_F   = 12;
  localparam int PERIOD_W = 12;
  localparam int PERIOD_F = 4;
  localparam int CONST_F  = 16;
endpackage

// File: rtl/quad2s_ctrl.sv
module quad2s_ctrl
  import quad2s_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleStb,
  output ctlStrobes_t ctl
);
  localparam int FILL_MAX = 2;

  logic [1:0] fillCnt;
  logic mulPend, mulPrimed, sumPend, sumPrimed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCnt   <= '0;
      mulPend   <= 1'b0;
      mulPrimed <= 1'b0;
      sumPend   <= 1'b0;
      sumPrimed <= 1'b0;
    end else begin
      if (sampleStb && fillCnt != 2'(FILL_MAX))
        fillCnt <= fillCnt + 2'd1;
      mulPend   <= sampleStb;
      mulPrimed <= sampleStb && (fillCnt == 2'(FILL_MAX));
      sumPend   <= mulPend;
      sumPrimed <= mulPrimed;
    end
  end

  always_comb begin
    ctl.shift  = sampleStb;
    ctl.mul    = mulPend;
    ctl.sum    = sumPend;
    ctl.primed = sumPrimed;
  end
endmodule

// File: rtl/quad2s_datapath.sv
module quad2s_datapath
  import quad2s_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int CW = COEF_W,
  parameter int CF = COEF_F,
  parameter int NW = PERIOD_W,
  parameter int NF = PERIOD_F,
  parameter int KF = CONST_F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          ctl,
  input  logic signed [DW-1:0] sampleIn,
  input  logic                 approxMode,
  input  logic        [NW-1:0] periodWord,
  input  logic signed [CW-1:0] phaseStep,
  input  logic signed [CW-1:0] invSinCoef,
  input  logic signed [CW-1:0] tanCoef,
  output logic signed [DW-1:0] alphaOut,
  output logic signed [DW-1:0] betaOut,
  output logic                 outValid
);
  localparam int    PA_W   = DW + CW + 1;      // product of difference and coefficient
  localparam int    PB_W   = DW + CW;          // product of sample and coefficient
  localparam int    SUM_W  = PA_W + 1;
  localparam int    NP_W   = NW + KF;
  localparam int    NSHIFT = NF + KF - CF;
  localparam real   PI_R   = 3.14159265358979;
  localparam int    INV4PI = int'(real'(64'(1) << KF) / (4.0 * PI_R));
  localparam logic [KF-1:0] INV4PI_W = KF'(INV4PI);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  // two-sample history plus current sample
  logic signed [DW-1:0] curS, prev1, prev2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curS  <= '0;
      prev1 <= '0;
      prev2 <= '0;
    end else if (ctl.shift) begin
      curS  <= sampleIn;
      prev1 <= curS;
      prev2 <= prev1;
    end
  end

  // coefficient selection: exact words or small-angle forms
  logic        [NP_W-1:0] nProd;
  logic signed [CW-1:0]   coefApprox, coefA, coefB;

  always_comb begin
    nProd      = NP_W'(periodWord) * NP_W'(INV4PI_W);
    coefApprox = nProd[NSHIFT +: CW];
    coefA      = approxMode ? coefApprox : invSinCoef;
    coefB      = approxMode ? phaseStep  : tanCoef;
  end

  // multiply stage, double-width products
  logic signed [DW:0]     diffS;
  logic signed [PA_W-1:0] prodA, prodANext;
  logic signed [PB_W-1:0] prodB, prodBNext;
  logic signed [DW-1:0]   alphaMul;

  always_comb begin
    diffS     = {prev2[DW-1], prev2} - {curS[DW-1], curS};
    prodANext = PA_W'(diffS) * PA_W'(coefA);
    prodBNext = PB_W'(curS) * PB_W'(coefB);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodA    <= '0;
      prodB    <= '0;
      alphaMul <= '0;
    end else if (ctl.mul) begin
      prodA    <= prodANext;
      prodB    <= prodBNext;
      alphaMul <= curS;
    end
  end

  // sum stage: add, scale, saturate once
  logic signed [SUM_W-1:0] sumFull, sumScaled;
  logic signed [DW-1:0]    betaSat;
  logic                    fitsOut;

  always_comb begin
    sumFull   = SUM_W'(prodA) + SUM_W'(prodB);
    sumScaled = sumFull >>> CF;
    fitsOut   = (&sumScaled[SUM_W-1:DW-1]) || !(|sumScaled[SUM_W-1:DW-1]);
    if (fitsOut)
      betaSat = sumScaled[DW-1:0];
    else if (sumScaled[SUM_W-1])
      betaSat = MINV;
    else
      betaSat = MAXV;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alphaOut <= '0;
      betaOut  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.sum && ctl.primed;
      if (ctl.sum) begin
        alphaOut <= alphaMul;
        betaOut  <= betaSat;
      end
    end
  end
endmodule

// File: rtl/quad_two_sample.sv
module quad_two_sample
  import quad2s_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int CW = COEF_W,
  parameter int CF = COEF_F,
  parameter int NW = PERIOD_W,
  parameter int NF = PERIOD_F,
  parameter int KF = CONST_F
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic signed [DW-1:0] sampleIn,
  input  logic                 sampleStb,
  input  logic                 approxMode,
  input  logic        [NW-1:0] periodWord,
  input  logic signed [CW-1:0] phaseStep,
  input  logic signed [CW-1:0] invSinCoef,
  input  logic signed [CW-1:0] tanCoef,
  output logic signed [DW-1:0] alphaOut,
  output logic signed [DW-1:0] betaOut,
  output logic                 outValid
);
  ctlStrobes_t ctl;

  quad2s_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleStb (sampleStb),
    .ctl       (ctl)
  );

  quad2s_datapath #(
    .DW(DW), .CW(CW), .CF(CF), .NW(NW), .NF(NF), .KF(KF)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .sampleIn   (sampleIn),
    .approxMode (approxMode),
    .periodWord (periodWord),
    .phaseStep  (phaseStep),
    .invSinCoef (invSinCoef),
    .tanCoef    (tanCoef),
    .alphaOut   (alphaOut),
    .betaOut    (betaOut),
    .outValid   (outValid)
  );
endmodule

// File: rtl/quad2s_checker.sv
module quad2s_checker #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 sampleStb,
  input logic signed [DW-1:0] sampleIn,
  input logic signed [DW-1:0] alphaOut,
  input logic signed [DW-1:0] betaOut,
  input logic                 outValid
);
  logic [1:0] stbSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbSeen <= '0;
    else if (sampleStb && stbSeen != 2'd3) stbSeen <= stbSeen + 2'd1;
  end

  AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> stbSeen == 2'd3); // R2
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(sampleStb, 3)); // R3
  AST_BETA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleStb, 3) |-> $stable(betaOut)); // R3
  AST_ALPHA_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> alphaOut == $past(sampleIn, 3)); // R7
  AST_ALPHA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleStb, 3) |-> $stable(alphaOut)); // R8
endmodule

bind quad_two_sample quad2s_checker #(.DW(DW)) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sampleStb (sampleStb),
  .sampleIn  (sampleIn),
  .alphaOut  (alphaOut),
  .betaOut   (betaOut),
  .outValid  (outValid)
);

// File: tb/test_quad_two_sample.sv
`timescale 1ns/1ps
module test_quad_two_sample;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic signed [15:0] sampleIn = '0;
  logic sampleStb = 1'b0;
  logic approxMode = 1'b0;
  logic [11:0] periodWord = '0;
  logic signed [17:0] phaseStep = '0, invSinCoef = '0, tanCoef = '0;
  logic signed [15:0] alphaOut, betaOut;
  logic outValid;

  always #2.5 clk = ~clk;   // 200 MHz

  quad_two_sample i_quad_two_sample (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleStb(sampleStb),
    .approxMode(approxMode), .periodWord(periodWord), .phaseStep(phaseStep),
    .invSinCoef(invSinCoef), .tanCoef(tanCoef),
    .alphaOut(alphaOut), .betaOut(betaOut), .outValid(outValid)
  );

  int errors = 0, checks = 0, posCnt = 0, validCnt = 0, sent = 0;
  int hist1 = 0, hist2 = 0;
  string curTag = "R4";
  int    qAlpha[$], qBeta[$], qCyc[$];
  string qTag[$];

  always @(posedge clk) posCnt++;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model(int older, int now);
    longint a, b, s;
    if (approxMode) begin
      a = (longint'(periodWord) * 5215) >>> 8;   // R5 constant path
      b = longint'(phaseStep);
    end else begin
      a = longint'(invSinCoef);
      b = longint'(tanCoef);
    end
    s = (longint'(older - now) * a + longint'(now) * b) >>> 12;
    if (s > 32767) s = 32767;        // R6
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic send(int v);
    @(negedge clk);
    sampleIn  = 16'(v);
    sampleStb = 1'b1;
    if (sent >= 2) begin
      qAlpha.push_back(v);
      qBeta.push_back(model(hist2, v));
      qCyc.push_back(posCnt + 3);
      qTag.push_back(curTag);
    end
    hist2 = hist1;
    hist1 = v;
    sent++;
  endtask

  task automatic idle(int n, int junk);
    @(negedge clk);
    sampleStb = 1'b0;
    sampleIn  = 16'(junk);   // R8: ignored without strobe
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    sampleStb = 1'b0;
    rstN = 1'b0;
    sent = 0; hist1 = 0; hist2 = 0;
    repeat (2) @(negedge clk);
    check("R1 outValid", outValid, 0);
    check("R1 alphaOut", alphaOut, 0);
    check("R1 betaOut", betaOut, 0);
    rstN = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        validCnt++;
        if (qBeta.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected outValid actual=1 expected=0");
        end else begin
          check("R3 latency", posCnt, qCyc.pop_front());
          check("R7 alphaOut", alphaOut, qAlpha.pop_front());
          check({qTag.pop_front(), " betaOut"}, betaOut, qBeta.pop_front());
        end
      end else if (qCyc.size() != 0 && qCyc[0] <= posCnt) begin
        checks++; errors++;
        $display("FAIL R3 missing outValid actual=0 expected=1");
        void'(qCyc.pop_front()); void'(qAlpha.pop_front());
        void'(qBeta.pop_front()); void'(qTag.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    doReset();
    // exact mode, N = 64
    approxMode = 1'b0;
    periodWord = 12'(64 * 16);
    invSinCoef = 18'($rtoi(4096.0 / $sin(4.0 * 3.14159265358979 / 64.0) + 0.5));
    tanCoef    = 18'($rtoi(4096.0 * $tan(2.0 * 3.14159265358979 / 64.0) + 0.5));
    curTag = "R4";
    send(0); idle(4, 12345);
    send(1000); idle(4, -999);
    check("R2 no valid for first two samples", validCnt, 0);
    for (int k = 2; k < 40; k++) begin
      send($rtoi(10000.0 * $sin(2.0 * 3.14159265358979 * k / 64.0)));
      idle(3, k * 777);
    end
    idle(5, 0);
    check("R2 one valid per later sample", validCnt, 38);

    // small-angle mode, N = 100
    approxMode = 1'b1;
    curTag = "R5";
    periodWord = 12'(100 * 16);
    phaseStep  = 18'($rtoi(4096.0 * 2.0 * 3.14159265358979 / 100.0 + 0.5));
    for (int k = 0; k < 30; k++) begin
      send($rtoi(20000.0 * $cos(2.0 * 3.14159265358979 * k / 100.0)));
      idle(2, -k * 321);
    end
    idle(5, 0);

    // saturation, exact mode with large coefficient
    approxMode = 1'b0;
    curTag = "R6";
    invSinCoef = 18'sd30000;
    tanCoef    = 18'sd4096;
    for (int k = 0; k < 10; k++) begin
      send((k % 2 == 0) ? 32000 : -32000);
      idle(2, 5);
    end
    send(-32768); idle(2, 0);
    send(32767);  idle(2, 0);
    idle(5, 0);

    // back-to-back strobes
    curTag = "R9";
    tanCoef    = 18'sd403;
    invSinCoef = 18'sd20996;
    for (int k = 0; k < 20; k++) send(k * 1500 - 14000);
    idle(6, 0);
    check("R9 queue drained", qBeta.size(), 0);

    // mid-run reset re-primes the history
    doReset();
    validCnt = 0;
    curTag = "R2";
    send(5000); idle(3, 1);
    send(-5000); idle(3, 2);
    idle(3, 3);
    check("R2 after mid reset", validCnt, 0);
    send(7000); idle(6, 4);
    check("R2 third sample after reset", validCnt, 1);
    check("R3 all results seen", qBeta.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule